// File: doc/BRIEF.md
# LVDS Display Pixel Formatter

This block sits between a parallel RGB video source and an external 7:1 LVDS serializer. On each pixel clock it takes one 24-bit pixel together with horizontal sync, vertical sync and data-enable. It produces the 7-bit parallel symbols for the clock lane and the four data lanes of one or two LVDS channels. The serializer shifts each symbol out starting at bit 6.

Each channel has two configuration bits. One selects 24 bpp output. The other selects where the two extra bits of each colour go: the low bits (Y3 carries the LSBs and Y0–Y2 carry bits 7:2) or the high bits (Y3 carries the MSBs and Y0–Y2 carry bits 5:0). With 24 bpp off, the fourth data lane is held low. This gives 18 bpp output, and with low-bit packing selected it also truncates 24 bpp input.

In dual-link mode, input pixels arrive at twice the link rate. The block pairs them and puts the first pixel of each pair on channel A and the second on channel B. A pending configuration is adopted only on a rising edge of vertical sync, so a frame is never split across two configurations.

Top module: `lvds_pix_fmt`

## Requirements
- R1: While rst_ni is low and after its release until the first formatted pixel, every lane output and sym_vld_o are zero.
- R2: In single-link mode a pixel sampled at rising edge k appears on the outputs after edge k+1, sym_vld_o is high every cycle, and cha_clk_o is 7'b1100011.
- R3: Lane n occupies data bits [7n+6:7n], and bit 6 is sent first. Using 6-bit fields R, G and B, the transmit order is: Y0 = R0..R5, G0; Y1 = G1..G5, B0, B1; Y2 = B2..B5, HS, VS, DE.
- R4: 24 bpp with low-bit packing (fmt1=1, bpp24=1): the 6-bit fields are colour bits 7:2. Y3 sends R0, R1, G0, G1, B0, B1, 0 in that order, taken from colour bits 1:0.
- R5: 24 bpp with high-bit packing (fmt1=0, bpp24=1): the 6-bit fields are colour bits 5:0. Y3 uses the same order with colour bits 7:6.
- R6: Truncation (fmt1=1, bpp24=0): the 6-bit fields are colour bits 7:2, and Y3 is all zero.
- R7: Native 18 bpp (fmt1=0, bpp24=0): the 6-bit fields are colour bits 5:0, and Y3 is all zero.
- R8: In single-link mode chb_clk_o and chb_data_o are all zero.
- R9: In dual-link mode, the first pixel of each input pair goes to channel A and the second to channel B. Both appear one edge after the second pixel is sampled. sym_vld_o pulses once per pair, and all lane outputs hold their values between pulses. chb_clk_o is 7'b1100011 on each pulse.
- R10: Channel A uses bit 0 and channel B uses bit 1 of ch_24bpp_i and ch_fmt1_i, independently of each other.
- R11: A pixel with de_i low sends all colour bits as zero, while HS, VS and DE are still sent.
- R12: Configuration inputs take effect from the pixel sampled with a rising vsync_i edge onward. Changes at any other time have no effect until the next rising vsync_i edge. After reset the configuration is single-link, 18 bpp, high-bit packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_link_i | input | 1 | Pending mode: 1 = dual link |
| ch_24bpp_i | input | 2 | Pending 24 bpp enable, bit 0 = A, bit 1 = B |
| ch_fmt1_i | input | 2 | Pending low-bit packing select, bit 0 = A, bit 1 = B |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| sym_vld_o | output | 1 | New symbols present this cycle |
| cha_clk_o | output | 7 | Channel A clock lane symbol |
| cha_data_o | output | 28 | Channel A data lanes Y3..Y0 |
| chb_clk_o | output | 7 | Channel B clock lane symbol |
| chb_data_o | output | 28 | Channel B data lanes Y3..Y0 |

## Verification
The pairing assertion assumes two things about the input in dual-link mode. First, every rising vsync_i edge falls on the first pixel of a pair. Second, every sync, blanking and active segment spans an even number of input cycles, so pair phase never slips across a configuration change. The stimulus builds every frame from segments of even length: two-cycle vsync pulses, four-cycle blanking and even active widths. It changes the pending configuration both mid-frame and between frames, and only switches link mode through a vsync edge that lands on a pair boundary.

// File: rtl/lvds_fmt_pkg.sv
package lvds_fmt_pkg;
  localparam int COLOR_W   = 8;
  localparam int LANE_BITS = 7;
  localparam int LANE_CNT  = 4;
  localparam int NUM_CH    = 2;
  localparam logic [LANE_BITS-1:0] CLK_PAT = 7'b1100011;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pix_t;

  typedef struct packed {
    logic              dual;
    logic [NUM_CH-1:0] bpp24;
    logic [NUM_CH-1:0] fmt1;
  } cfg_t;
endpackage

// File: rtl/lvds_cfg_sync.sv
module lvds_cfg_sync
  import lvds_fmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_eff_o
);
  logic vs_q;
  cfg_t cfg_q;
  logic vs_rise;

  assign vs_rise   = vs_i & ~vs_q;
  // pending config becomes live on the vsync rising pixel itself
  assign cfg_eff_o = vs_rise ? cfg_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      vs_q  <= vs_i;
      cfg_q <= cfg_eff_o;
    end
  end
endmodule

// File: rtl/lvds_pair_capture.sv
module lvds_pair_capture
  import lvds_fmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  pix_t pix_i,
  input  cfg_t cfg_eff_i,
  output pix_t odd_o,
  output pix_t even_o,
  output cfg_t cfg_o,
  output logic vld_o
);
  logic phase_q;
  pix_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
      odd_o   <= '0;
      even_o  <= '0;
      cfg_o   <= '0;
      vld_o   <= 1'b0;
    end else if (!cfg_eff_i.dual) begin
      phase_q <= 1'b0;
      odd_o   <= pix_i;
      even_o  <= '0;
      cfg_o   <= cfg_eff_i;
      vld_o   <= 1'b1;
    end else if (!phase_q) begin
      phase_q <= 1'b1;
      hold_q  <= pix_i;
      vld_o   <= 1'b0;
    end else begin
      phase_q <= 1'b0;
      odd_o   <= hold_q;
      even_o  <= pix_i;
      cfg_o   <= cfg_eff_i;
      vld_o   <= 1'b1;
    end
  end

  AST_PAIR_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && cfg_o.dual && cfg_eff_i.dual) |=> !vld_o); // R9
endmodule

// File: rtl/lvds_chan_map.sv
module lvds_chan_map
  import lvds_fmt_pkg::*;
#(
  parameter int LANE_W  = LANE_BITS,
  parameter int N_LANES = LANE_CNT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic                      en_i,
  input  logic                      bpp24_i,
  input  logic                      fmt1_i,
  input  pix_t                      pix_i,
  output logic [LANE_W-1:0]         clk_o,
  output logic [N_LANES*LANE_W-1:0] data_o
);
  localparam int SIX_W = COLOR_W - 2;
  localparam int EXT_W = COLOR_W - SIX_W;
  localparam int DW    = N_LANES * LANE_W;
  // colour-bit positions: Y0, Y1 full, Y2 bits 6:3, Y3 bits 6:1
  localparam logic [DW-1:0] COLOR_MASK = {7'h7E, 7'h78, 7'h7F, 7'h7F};

  logic [2:0][COLOR_W-1:0] col;
  logic [2:0][SIX_W-1:0]   six;
  logic [2:0][EXT_W-1:0]   ext;
  logic [LANE_W-1:0]       y0, y1, y2, y3;

  assign col[0] = pix_i.de ? pix_i.r : '0;
  assign col[1] = pix_i.de ? pix_i.g : '0;
  assign col[2] = pix_i.de ? pix_i.b : '0;

  for (genvar c = 0; c < 3; c++) begin : g_split
    assign six[c] = fmt1_i ? col[c][COLOR_W-1:EXT_W] : col[c][SIX_W-1:0];
    assign ext[c] = fmt1_i ? col[c][EXT_W-1:0]       : col[c][COLOR_W-1:SIX_W];
  end

  // bit 6 leaves the serializer first
  assign y0 = {six[0][0], six[0][1], six[0][2], six[0][3], six[0][4], six[0][5], six[1][0]};
  assign y1 = {six[1][1], six[1][2], six[1][3], six[1][4], six[1][5], six[2][0], six[2][1]};
  assign y2 = {six[2][2], six[2][3], six[2][4], six[2][5], pix_i.hs, pix_i.vs, pix_i.de};
  assign y3 = bpp24_i ? {ext[0][0], ext[0][1], ext[1][0], ext[1][1], ext[2][0], ext[2][1], 1'b0}
                      : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_o  <= '0;
      data_o <= '0;
    end else if (vld_i) begin
      clk_o  <= en_i ? CLK_PAT : '0;
      data_o <= en_i ? {y3, y2, y1, y0} : '0;
    end
  end

  AST_Y3_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !bpp24_i) |=> (data_o[DW-1:DW-LANE_W] == '0)); // R6
  AST_BLANK_COLOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !pix_i.de) |=> ((data_o & COLOR_MASK) == '0)); // R11
  AST_CH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !en_i) |=> (data_o == '0 && clk_o == '0)); // R8
endmodule

// File: rtl/lvds_pix_fmt.sv
module lvds_pix_fmt
  import lvds_fmt_pkg::*;
#(
  parameter int LANE_W  = LANE_BITS,
  parameter int N_LANES = LANE_CNT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dual_link_i,
  input  logic [1:0]                ch_24bpp_i,
  input  logic [1:0]                ch_fmt1_i,
  input  logic [7:0]                red_i,
  input  logic [7:0]                grn_i,
  input  logic [7:0]                blu_i,
  input  logic                      hsync_i,
  input  logic                      vsync_i,
  input  logic                      de_i,
  output logic                      sym_vld_o,
  output logic [LANE_W-1:0]         cha_clk_o,
  output logic [N_LANES*LANE_W-1:0] cha_data_o,
  output logic [LANE_W-1:0]         chb_clk_o,
  output logic [N_LANES*LANE_W-1:0] chb_data_o
);
  localparam int DW = N_LANES * LANE_W;

  cfg_t cfg_in, cfg_eff, cfg_pair;
  pix_t pix_in, pix_odd, pix_even;
  logic pair_vld;
  logic out_dual_q;
  logic [NUM_CH-1:0][LANE_W-1:0] ch_clk;
  logic [NUM_CH-1:0][DW-1:0]     ch_data;

  assign cfg_in = '{dual: dual_link_i, bpp24: ch_24bpp_i, fmt1: ch_fmt1_i};
  assign pix_in = '{r: red_i, g: grn_i, b: blu_i, hs: hsync_i, vs: vsync_i, de: de_i};

  lvds_cfg_sync u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vs_i     (vsync_i),
    .cfg_i    (cfg_in),
    .cfg_eff_o(cfg_eff)
  );

  lvds_pair_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_i    (pix_in),
    .cfg_eff_i(cfg_eff),
    .odd_o    (pix_odd),
    .even_o   (pix_even),
    .cfg_o    (cfg_pair),
    .vld_o    (pair_vld)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    lvds_chan_map #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_map (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (pair_vld),
      .en_i   ((ch == 0) ? 1'b1 : cfg_pair.dual),
      .bpp24_i(cfg_pair.bpp24[ch]),
      .fmt1_i (cfg_pair.fmt1[ch]),
      .pix_i  ((ch == 0) ? pix_odd : pix_even),
      .clk_o  (ch_clk[ch]),
      .data_o (ch_data[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_vld_o  <= 1'b0;
      out_dual_q <= 1'b0;
    end else begin
      sym_vld_o <= pair_vld;
      if (pair_vld) out_dual_q <= cfg_pair.dual;
    end
  end

  assign cha_clk_o  = ch_clk[0];
  assign cha_data_o = ch_data[0];
  assign chb_clk_o  = ch_clk[1];
  assign chb_data_o = ch_data[1];

  AST_A_CLK_PAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> (cha_clk_o == CLK_PAT)); // R2
  AST_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_vld_o && !out_dual_q) |-> (chb_clk_o == '0 && chb_data_o == '0)); // R8
  AST_HOLD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> ($stable(cha_data_o) && $stable(chb_data_o))); // R9
endmodule

// File: tb/lvds_pix_fmt_bench.sv
module lvds_pix_fmt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual = 1'b0;
  logic [1:0] b24 = 2'b00, f1 = 2'b00;
  logic [7:0] r = '0, g = '0, b = '0;
  logic hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic sym_vld;
  logic [6:0] a_clk, b_clk;
  logic [27:0] a_dat, b_dat;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  lvds_pix_fmt u_lvds_pix_fmt (
    .clk_i(clk), .rst_ni(rst_n), .dual_link_i(dual), .ch_24bpp_i(b24), .ch_fmt1_i(f1),
    .red_i(r), .grn_i(g), .blu_i(b), .hsync_i(hs), .vsync_i(vs), .de_i(de),
    .sym_vld_o(sym_vld), .cha_clk_o(a_clk), .cha_data_o(a_dat),
    .chb_clk_o(b_clk), .chb_data_o(b_dat)
  );

  // behavioural model: serial bit stream packed into lanes
  function automatic logic [34:0] ref_fmt(input logic [7:0] pr, pg, pb,
                                          input logic phs, pvs, pde,
                                          input logic w24, lowpack, en);
    logic st[28];
    logic [27:0] d;
    logic [7:0] cc[3];
    logic [5:0] s[3];
    logic [1:0] x[3];
    int k;
    if (!en) return '0;
    cc[0] = pde ? pr : 8'h00;
    cc[1] = pde ? pg : 8'h00;
    cc[2] = pde ? pb : 8'h00;
    for (int i = 0; i < 3; i++) begin
      s[i] = lowpack ? 6'(cc[i] >> 2) : 6'(cc[i] & 8'h3F);
      x[i] = lowpack ? 2'(cc[i] & 8'h03) : 2'(cc[i] >> 6);
    end
    k = 0;
    for (int i = 0; i < 6; i++) begin st[k] = s[0][i]; k++; end
    for (int i = 0; i < 6; i++) begin st[k] = s[1][i]; k++; end
    for (int i = 0; i < 6; i++) begin st[k] = s[2][i]; k++; end
    st[k] = phs; k++;
    st[k] = pvs; k++;
    st[k] = pde; k++;
    for (int i = 0; i < 3; i++) begin
      st[k] = w24 & x[i][0]; k++;
      st[k] = w24 & x[i][1]; k++;
    end
    st[k] = 1'b0;
    for (int n = 0; n < 4; n++)
      for (int j = 0; j < 7; j++)
        d[7*n + 6 - j] = st[7*n + j];
    return {7'b1100011, d};
  endfunction

  logic m_vs, m_ph, m_dual;
  logic [1:0] m_b24, m_f1;
  logic [7:0] h_r, h_g, h_b;
  logic h_hs, h_vs, h_de;
  logic p_vld, e_vld;
  logic [34:0] p_a, p_b, e_a, e_b;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vs = 0; m_ph = 0; m_dual = 0; m_b24 = 0; m_f1 = 0;
      h_r = 0; h_g = 0; h_b = 0; h_hs = 0; h_vs = 0; h_de = 0;
      p_vld = 0; e_vld = 0; p_a = '0; p_b = '0; e_a = '0; e_b = '0;
    end else begin
      e_vld = p_vld;
      if (p_vld) begin e_a = p_a; e_b = p_b; end
      if (vs && !m_vs) begin m_dual = dual; m_b24 = b24; m_f1 = f1; end
      m_vs = vs;
      if (!m_dual) begin
        p_vld = 1; m_ph = 0;
        p_a = ref_fmt(r, g, b, hs, vs, de, m_b24[0], m_f1[0], 1'b1);
        p_b = '0;
      end else if (!m_ph) begin
        p_vld = 0; m_ph = 1;
        h_r = r; h_g = g; h_b = b; h_hs = hs; h_vs = vs; h_de = de;
      end else begin
        p_vld = 1; m_ph = 0;
        p_a = ref_fmt(h_r, h_g, h_b, h_hs, h_vs, h_de, m_b24[0], m_f1[0], 1'b1);
        p_b = ref_fmt(r, g, b, hs, vs, de, m_b24[1], m_f1[1], 1'b1);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if ({a_clk, a_dat} !== e_a) begin
        fails++;
        $display("FAIL %s chA actual=%h expected=%h", cur_req, {a_clk, a_dat}, e_a);
      end
      checks++;
      if ({b_clk, b_dat} !== e_b) begin
        fails++;
        $display("FAIL %s chB actual=%h expected=%h", cur_req, {b_clk, b_dat}, e_b);
      end
      checks++;
      if (sym_vld !== e_vld) begin
        fails++;
        $display("FAIL %s vld actual=%0b expected=%0b", cur_req, sym_vld, e_vld);
      end
    end
  end

  task automatic put(input logic [7:0] pr, pg, pb, input logic phs, pvs, pde);
    r = pr; g = pg; b = pb; hs = phs; vs = pvs; de = pde;
    @(negedge clk);
  endtask

  task automatic frame(input int lines, input int width, input int seed);
    put(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    put(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
    for (int l = 0; l < lines; l++) begin
      put(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      put(8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 1'b0); // colour during blanking must vanish (R11)
      put(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      put(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
      for (int p = 0; p < width; p++)
        put(8'((seed + p*37 + l*11) & 255), 8'((seed*3 + p*91 + 7) & 255),
            8'((seed*5 + p*53 + l) & 255), 1'b0, 1'b0, 1'b1);
    end
  endtask

  task automatic chk(input string req, input logic [27:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", {a_dat}, 28'h0);
    chk("R1", {b_dat}, 28'h0);
    chk("R1", {21'h0, a_clk} | {27'h0, sym_vld}, 28'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);

    // native 18 bpp, single link
    cur_req = "R7";
    frame(2, 8, 3);
    cur_req = "R3";
    put(8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
    put(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", {21'h0, a_dat[6:0]}, 28'h40);
    chk("R3", {21'h0, a_dat[20:14]}, 28'h05);
    chk("R2", {21'h0, a_clk}, 28'h63);
    put(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    cur_req = "R4"; dual = 0; b24 = 2'b01; f1 = 2'b01;
    frame(2, 8, 17);
    cur_req = "R5"; b24 = 2'b01; f1 = 2'b00;
    frame(2, 6, 101);
    cur_req = "R6"; b24 = 2'b00; f1 = 2'b01;
    frame(2, 6, 55);
    // mid-frame change must wait for next vsync
    cur_req = "R12";
    put(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    put(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    b24 = 2'b01; f1 = 2'b00;
    for (int p = 0; p < 6; p++) put(8'hC3, 8'h81, 8'h7E, 1'b0, 1'b0, 1'b1);
    chk("R12", {21'h0, a_dat[27:21]}, 28'h0);
    frame(1, 4, 9);

    cur_req = "R9"; dual = 1; b24 = 2'b11; f1 = 2'b01;
    frame(2, 8, 77);
    cur_req = "R10"; b24 = 2'b10; f1 = 2'b01;
    frame(2, 8, 201);
    b24 = 2'b01; f1 = 2'b10;
    frame(1, 6, 33);
    cur_req = "R8"; dual = 0; b24 = 2'b00; f1 = 2'b00;
    frame(2, 6, 5);
    cur_req = "R11";
    for (int p = 0; p < 4; p++) put(8'hFF, 8'hFF, 8'hFF, p[0], 1'b0, 1'b0);
    @(negedge clk);
    cmp_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule